// File: doc/BRIEF.md
# Frame Header Aligner with Bitslip Control

This block finds the frame boundary on a word-parallel serial receive link. One frame is several received words long, and its first word carries a short header field in its top bits. The block counts accepted words to find each frame's first word and checks its header. While alignment is unknown, it asks the transceiver to drop one bit of the incoming stream and then waits for a guard time, repeating this until enough frames in a row carry a valid header. One-bit slides eventually cover every bit position of the frame, because each group of word-width slides also moves the word phase by one word.

Once aligned, the block raises a locked flag and tolerates a limited number of corrupted headers inside a sliding budget of frames. It falls back to searching only when that budget is exceeded. A build option drives a transceiver reset pulse after slides that leave the slide position even, for systems that need a fixed receive latency.

Top module: `frame_header_aligner`

## Requirements
- R1: Words are counted only when `rx_valid` is high. The first accepted word after reset is word 0 of a frame, and every 8th accepted word after it is also word 0. `frame_strobe` is high for exactly one cycle, in the cycle after each word 0 is accepted.
- R2: The header is `rx_word[31:30]` of word 0. The codes 2'b01 and 2'b10 are valid, and 2'b00 and 2'b11 are invalid. Valid headers never cause a slide.
- R3: After reset, `locked`, `slip_req`, `frame_strobe` and `xcvr_rst` are low. `locked` rises in the cycle after the 32nd valid header of an unbroken run, and not before that header.
- R4: While unlocked, an invalid header raises `slip_req` for exactly 2 cycles and clears the run of valid headers, so 32 fresh valid headers are needed afterwards.
- R5: After `slip_req` falls, headers are ignored for at least 40 cycles. A header that arrives after the guard is judged again.
- R6: While locked, up to 5 invalid headers within one 64-frame window leave `locked` high. The 6th invalid header in the same window drops `locked`.
- R7: The 64-frame window starts with the first header after lock. The window count and the invalid-header count both clear when the window ends, so invalid headers do not carry over into the next window.
- R8: `slip_req` is never high while `locked` is high, and losing lock does not slide by itself. After loss of lock, the next invalid header slides.
- R9: A slide counter counts slides modulo 32 from zero at reset. When a slide makes this count even, `xcvr_rst` is high for exactly 10 cycles, starting in the cycle `slip_req` rises. Otherwise `xcvr_rst` stays low.
- R10: For a bitstream of 256-bit frames whose first two bits are a valid header, the block locks from any starting bit offset. When it locks, word 0 begins exactly at a frame boundary, and lock then holds on clean data with no further slides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_word | input | 32 | Received parallel word; the first bit received is the MSB |
| rx_valid | input | 1 | Qualifies `rx_word` in this cycle |
| slip_req | output | 1 | Request to the transceiver to drop one received bit |
| frame_strobe | output | 1 | One-cycle pulse marking each frame's first word |
| locked | output | 1 | Frame alignment established |
| xcvr_rst | output | 1 | Transceiver reset after even-position slides |

## Verification
A wrong word index shows at the ports within one frame: `frame_strobe` appears at the wrong spacing, and after a slide search the lock lands on a word that is not a frame boundary. A run counter that fails to clear, or that clears wrongly, moves the `locked` edge away from the 32nd header. A window that never clears, or that clears early, changes which invalid header drops lock, and this shows within one or two windows. A slide-position or guard fault shows up directly in the width and count of the `slip_req` and `xcvr_rst` pulses after the first two slides.

// File: rtl/fha_pkg.sv
package fha_pkg;

   typedef enum logic [2:0] {
      ST_RESET      = 3'd0,
      ST_SEARCH     = 3'd1,
      ST_SLIDE_WAIT = 3'd2,
      ST_CONFIRM    = 3'd3,
      ST_LOCKED     = 3'd4
   } fha_state_e;

endpackage

// File: rtl/fha_frame_tracker.sv
// Counts accepted words inside a frame and judges the header of word 0.
module fha_frame_tracker #(
   parameter int          WORD_W          = 32,
   parameter int          WORDS_PER_FRAME = 8,
   parameter int          HDR_W           = 2,
   parameter logic [HDR_W-1:0] HDR_PAT_A  = 2'b01,
   parameter logic [HDR_W-1:0] HDR_PAT_B  = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_valid,
   output logic              hdr_evt,
   output logic              hdr_ok
);

   localparam int IDX_W = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS_PER_FRAME - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [HDR_W-1:0]  hdr_field;
   logic              hdr_match;
   logic              first_word;
   logic              unused_payload;

   assign hdr_field      = rx_word[WORD_W-1 -: HDR_W];
   assign unused_payload = ^rx_word[WORD_W-HDR_W-1:0];
   assign first_word     = rx_valid && (idx_q == '0);

   generate
      if (HDR_PAT_A == HDR_PAT_B) begin : g_single_pattern
         assign hdr_match = (hdr_field == HDR_PAT_A);
      end else begin : g_dual_pattern
         assign hdr_match = (hdr_field == HDR_PAT_A) || (hdr_field == HDR_PAT_B);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (rx_valid) begin
         if (idx_q == IDX_LAST) begin
            idx_q <= '0;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_evt <= 1'b0;
         hdr_ok  <= 1'b0;
      end else begin
         hdr_evt <= first_word;
         hdr_ok  <= first_word && hdr_match;
      end
   end

endmodule

// File: rtl/fha_slip_ctrl.sv
// Produces the slide pulse, the guard time after it and the optional
// transceiver reset after slides that leave the position even.
module fha_slip_ctrl #(
   parameter int WORD_W       = 32,
   parameter int SLIP_CYCLES  = 2,
   parameter int GUARD_CYCLES = 40,
   parameter bit EVEN_RST_EN  = 1'b1,
   parameter int RST_CYCLES   = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slide_go,
   output logic slip_req,
   output logic busy,
   output logic xcvr_rst
);

   localparam int PULSE_W = $clog2(SLIP_CYCLES + 1);
   localparam int GUARD_W = $clog2(GUARD_CYCLES + 1);

   logic [PULSE_W-1:0] pulse_q;
   logic [GUARD_W-1:0] guard_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= '0;
         guard_q <= '0;
      end else if (slide_go && (pulse_q == '0) && (guard_q == '0)) begin
         pulse_q <= PULSE_W'(SLIP_CYCLES);
      end else if (pulse_q != '0) begin
         pulse_q <= pulse_q - PULSE_W'(1);
         if (pulse_q == PULSE_W'(1)) begin
            guard_q <= GUARD_W'(GUARD_CYCLES);
         end
      end else if (guard_q != '0) begin
         guard_q <= guard_q - GUARD_W'(1);
      end
   end

   assign slip_req = (pulse_q != '0);
   assign busy     = (pulse_q != '0) || (guard_q != '0);

   generate
      if (EVEN_RST_EN) begin : g_even_reset
         localparam int POS_W = $clog2(WORD_W);
         localparam int RST_W = $clog2(RST_CYCLES + 1);

         logic [POS_W-1:0] pos_q;
         logic [POS_W-1:0] pos_next;
         logic [RST_W-1:0] rst_q;

         assign pos_next = pos_q + POS_W'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pos_q <= '0;
               rst_q <= '0;
            end else if (slide_go && !busy) begin
               pos_q <= pos_next;
               if (!pos_next[0]) begin
                  rst_q <= RST_W'(RST_CYCLES);
               end else if (rst_q != '0) begin
                  rst_q <= rst_q - RST_W'(1);
               end
            end else if (rst_q != '0) begin
               rst_q <= rst_q - RST_W'(1);
            end
         end

         assign xcvr_rst = (rst_q != '0);
      end else begin : g_no_reset
         assign xcvr_rst = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fha_loss_window.sv
// Counts invalid headers over a fixed window of frames while locked.
module fha_loss_window #(
   parameter int WIN_FRAMES = 64,
   parameter int BAD_LIMIT  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic hdr_evt,
   input  logic hdr_ok,
   output logic lose
);

   localparam int WIN_W = $clog2(WIN_FRAMES);
   localparam int BAD_W = $clog2(BAD_LIMIT + 1);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_FRAMES - 1);
   localparam logic [BAD_W-1:0] BAD_MAX  = BAD_W'(BAD_LIMIT);

   logic [WIN_W-1:0] win_q;
   logic [BAD_W-1:0] bad_q;

   assign lose = active && hdr_evt && !hdr_ok && (bad_q == BAD_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         bad_q <= '0;
      end else if (!active) begin
         win_q <= '0;
         bad_q <= '0;
      end else if (hdr_evt) begin
         if (lose || (win_q == WIN_LAST)) begin
            win_q <= '0;
            bad_q <= '0;
         end else begin
            win_q <= win_q + WIN_W'(1);
            if (!hdr_ok) begin
               bad_q <= bad_q + BAD_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/fha_align_fsm.sv
// Alignment state machine: search, slide, confirm and lock.
module fha_align_fsm
   import fha_pkg::*;
#(
   parameter int GOOD_TO_LOCK = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hdr_evt,
   input  logic hdr_ok,
   input  logic slip_busy,
   input  logic lose,
   output logic slide_go,
   output logic locked
);

   localparam int RUN_W = $clog2(GOOD_TO_LOCK + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_TO_LOCK - 1);

   fha_state_e       state_q, state_d;
   logic [RUN_W-1:0] run_q, run_d;

   always_comb begin
      state_d  = state_q;
      run_d    = run_q;
      slide_go = 1'b0;
      case (state_q)
         ST_RESET: begin
            state_d = ST_SEARCH;
            run_d   = '0;
         end
         ST_SEARCH, ST_CONFIRM: begin
            if (hdr_evt) begin
               if (hdr_ok) begin
                  if (run_q == RUN_LAST) begin
                     state_d = ST_LOCKED;
                     run_d   = '0;
                  end else begin
                     state_d = ST_CONFIRM;
                     run_d   = run_q + RUN_W'(1);
                  end
               end else begin
                  slide_go = 1'b1;
                  run_d    = '0;
                  state_d  = ST_SLIDE_WAIT;
               end
            end
         end
         ST_SLIDE_WAIT: begin
            if (!slip_busy) begin
               state_d = ST_SEARCH;
            end
         end
         ST_LOCKED: begin
            if (lose) begin
               state_d = ST_SEARCH;
            end
         end
         default: begin
            state_d = ST_SEARCH;
            run_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RESET;
         run_q   <= '0;
      end else begin
         state_q <= state_d;
         run_q   <= run_d;
      end
   end

   assign locked = (state_q == ST_LOCKED);

endmodule

// File: rtl/frame_header_aligner.sv
// Top level: frame header aligner with bitslip request.
module frame_header_aligner #(
   parameter int WORD_W          = 32,
   parameter int WORDS_PER_FRAME = 8,
   parameter int HDR_W           = 2,
   parameter logic [HDR_W-1:0] HDR_PAT_A = 2'b01,
   parameter logic [HDR_W-1:0] HDR_PAT_B = 2'b10,
   parameter int GOOD_TO_LOCK    = 32,
   parameter int WIN_FRAMES      = 64,
   parameter int BAD_LIMIT       = 5,
   parameter int SLIP_CYCLES     = 2,
   parameter int GUARD_CYCLES    = 40,
   parameter bit EVEN_RST_EN     = 1'b1,
   parameter int RST_CYCLES      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              rx_valid,
   output logic              slip_req,
   output logic              frame_strobe,
   output logic              locked,
   output logic              xcvr_rst
);

   generate
      if (HDR_W < 1 || HDR_W >= WORD_W) begin : g_chk_hdr
         $error("header width must be at least 1 and below the word width");
      end
      if (WORDS_PER_FRAME < 2) begin : g_chk_frame
         $error("a frame must span at least two words");
      end
      if (GOOD_TO_LOCK < 1) begin : g_chk_good
         $error("lock run must be at least one frame");
      end
      if (WIN_FRAMES < 2 || BAD_LIMIT < 1 || BAD_LIMIT >= WIN_FRAMES) begin : g_chk_win
         $error("loss window must exceed the invalid-header limit");
      end
      if (SLIP_CYCLES < 1 || GUARD_CYCLES < 1 || RST_CYCLES < 1) begin : g_chk_slip
         $error("slide, guard and reset durations must be positive");
      end
      if (WORD_W < 2) begin : g_chk_word
         $error("word width must be at least two bits");
      end
   endgenerate

   logic hdr_evt;
   logic hdr_ok;
   logic slide_go;
   logic slip_busy;
   logic lose;

   fha_frame_tracker #(
      .WORD_W          (WORD_W),
      .WORDS_PER_FRAME (WORDS_PER_FRAME),
      .HDR_W           (HDR_W),
      .HDR_PAT_A       (HDR_PAT_A),
      .HDR_PAT_B       (HDR_PAT_B)
   ) u_tracker (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_word  (rx_word),
      .rx_valid (rx_valid),
      .hdr_evt  (hdr_evt),
      .hdr_ok   (hdr_ok)
   );

   fha_align_fsm #(
      .GOOD_TO_LOCK (GOOD_TO_LOCK)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .hdr_evt   (hdr_evt),
      .hdr_ok    (hdr_ok),
      .slip_busy (slip_busy),
      .lose      (lose),
      .slide_go  (slide_go),
      .locked    (locked)
   );

   fha_loss_window #(
      .WIN_FRAMES (WIN_FRAMES),
      .BAD_LIMIT  (BAD_LIMIT)
   ) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (locked),
      .hdr_evt (hdr_evt),
      .hdr_ok  (hdr_ok),
      .lose    (lose)
   );

   fha_slip_ctrl #(
      .WORD_W       (WORD_W),
      .SLIP_CYCLES  (SLIP_CYCLES),
      .GUARD_CYCLES (GUARD_CYCLES),
      .EVEN_RST_EN  (EVEN_RST_EN),
      .RST_CYCLES   (RST_CYCLES)
   ) u_slip (
      .clk      (clk),
      .rst_n    (rst_n),
      .slide_go (slide_go),
      .slip_req (slip_req),
      .busy     (slip_busy),
      .xcvr_rst (xcvr_rst)
   );

   assign frame_strobe = hdr_evt;

endmodule

// File: rtl/fha_checker.sv
// Temporal checks on the aligner, attached by bind.
module fha_checker (
   input logic clk,
   input logic rst_n,
   input logic slip_req,
   input logic frame_strobe,
   input logic locked,
   input logic xcvr_rst,
   input logic slip_busy
);

   a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_strobe |=> !frame_strobe);

   a_r3_lock_after_header: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(frame_strobe));

   a_r4_slip_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slip_req) |=> slip_req);

   a_r5_guard_after_slip: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slip_req) |-> slip_busy);

   a_r5_slide_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slip_req) |-> !$past(slip_busy));

   a_r8_no_slip_locked: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !slip_req);

   a_r9_reset_with_slide: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xcvr_rst) |-> $rose(slip_req));

endmodule

bind frame_header_aligner fha_checker u_fha_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .slip_req     (slip_req),
   .frame_strobe (frame_strobe),
   .locked       (locked),
   .xcvr_rst     (xcvr_rst),
   .slip_busy    (slip_busy)
);

// File: tb/frame_header_aligner_bench.sv
module frame_header_aligner_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] rx_word;
   logic        rx_valid;
   logic        slip_req;
   logic        frame_strobe;
   logic        locked;
   logic        xcvr_rst;

   int checks = 0;
   int failures = 0;

   // monitor statistics
   int  slip_w = 0, last_slip_w = 0, slip_rises = 0;
   int  rst_w = 0, last_rst_w = 0, rst_rises = 0;
   int  strobe_cnt = 0, lock_slip_viol = 0;
   bit  slip_prev = 0, rst_prev = 0;

   // stimulus bookkeeping
   int     widx = 0;
   int     frames_started = 0;
   longint ptr = 0;
   longint w0_ptr = 0;
   bit     m_prev = 0;

   always #10 clk = ~clk;

   frame_header_aligner u_frame_header_aligner (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_word      (rx_word),
      .rx_valid     (rx_valid),
      .slip_req     (slip_req),
      .frame_strobe (frame_strobe),
      .locked       (locked),
      .xcvr_rst     (xcvr_rst)
   );

   always begin
      @(posedge clk);
      #5;
      if (slip_req) slip_w++;
      else if (slip_w != 0) begin last_slip_w = slip_w; slip_w = 0; end
      if (slip_req && !slip_prev) slip_rises++;
      slip_prev = slip_req;
      if (xcvr_rst) rst_w++;
      else if (rst_w != 0) begin last_rst_w = rst_w; rst_w = 0; end
      if (xcvr_rst && !rst_prev) rst_rises++;
      rst_prev = xcvr_rst;
      if (frame_strobe) strobe_cnt++;
      if (locked && slip_req) lock_slip_viol++;
   end

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic put(logic [31:0] w, bit v);
      @(negedge clk);
      rx_word  = w;
      rx_valid = v;
      if (v) begin
         if (widx == 0) frames_started++;
         widx = (widx + 1) % 8;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) put(32'h0, 1'b0);
   endtask

   task automatic send_frame(logic [1:0] hdr, bit gaps);
      logic [31:0] r;
      for (int i = 0; i < 8; i++) begin
         if (gaps) begin
            while (($urandom % 4) == 0) put($urandom, 1'b0);
         end
         r = $urandom;
         if (i == 0) put({hdr, r[29:0]}, 1'b1);
         else        put(r, 1'b1);
      end
   endtask

   // deterministic pseudo-random payload bit for stream position n
   function automatic bit pay_bit(longint n);
      logic [31:0] x;
      x = n[31:0] * 32'h9E3779B1;
      x = x ^ (x >> 15);
      x = x * 32'h85EBCA6B;
      x = x ^ (x >> 13);
      return x[7];
   endfunction

   function automatic bit stream_bit(longint n);
      longint p;
      p = n % 256;
      if (p == 0) return 1'b1;
      if (p == 1) return 1'b0;
      return pay_bit(n);
   endfunction

   function automatic logic [31:0] word_at(longint p);
      logic [31:0] w;
      for (int i = 0; i < 32; i++) w[31-i] = stream_bit(p + i);
      return w;
   endfunction

   task automatic model_cycle();
      @(negedge clk);
      if (slip_req && !m_prev) ptr++;
      m_prev = slip_req;
      if (($urandom % 4) != 0) begin
         if (widx == 0) w0_ptr = ptr;
         rx_word  = word_at(ptr);
         rx_valid = 1'b1;
         ptr      = ptr + 32;
         widx     = (widx + 1) % 8;
      end else begin
         rx_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int base;
      int sr;
      void'($urandom(32'd20231));
      rst_n    = 1'b0;
      rx_word  = '0;
      rx_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3", "locked in reset", locked, 0);
      chk("R3", "slip_req in reset", slip_req, 0);
      rst_n = 1'b1;
      idle(2);
      chk("R3", "locked after reset", locked, 0);
      chk("R3", "frame_strobe after reset", frame_strobe, 0);
      chk("R3", "xcvr_rst after reset", xcvr_rst, 0);

      // R1: exact strobe timing, idle cycles do not count
      put({2'b01, 30'h1234567}, 1'b1);
      put(32'h0, 1'b0);
      chk("R1", "strobe cycle after word 0", frame_strobe, 1);
      put(32'h0, 1'b0);
      chk("R1", "strobe single cycle", frame_strobe, 0);
      for (int i = 1; i < 8; i++) begin
         put(32'hFFFF_FFFF, 1'b0);
         put($urandom, 1'b1);
      end

      // R2/R3: lock after the 32nd valid header
      for (int k = 2; k <= 31; k++) send_frame((k % 2) ? 2'b10 : 2'b01, 1'b1);
      idle(2);
      chk("R3", "not locked after 31 headers", locked, 0);
      send_frame(2'b10, 1'b1);
      idle(2);
      chk("R3", "locked after 32 headers", locked, 1);
      chk("R2", "valid headers cause no slide", slip_rises, 0);

      // R6/R7: windowed loss of lock
      for (int f = 0; f < 64; f++) begin
         if (f >= 59) send_frame((f % 2) ? 2'b00 : 2'b11, 1'b1);
         else         send_frame(2'b10, 1'b1);
      end
      idle(2);
      chk("R6", "five invalid headers tolerated", locked, 1);
      send_frame(2'b00, 1'b1);
      idle(2);
      chk("R7", "window cleared at its end", locked, 1);
      for (int f = 0; f < 4; f++) send_frame(2'b11, 1'b1);
      idle(2);
      chk("R6", "five invalid in second window", locked, 1);
      send_frame(2'b00, 1'b1);
      idle(2);
      chk("R6", "sixth invalid drops lock", locked, 0);
      chk("R8", "loss of lock does not slide", slip_rises, 0);

      // R8/R4/R9: first slide after loss of lock
      idle(3);
      send_frame(2'b11, 1'b0);
      idle(4);
      chk("R8", "invalid header slides after loss", slip_rises, 1);
      chk("R4", "slide pulse width", last_slip_w, 2);
      chk("R9", "odd position gives no reset", rst_rises, 0);

      // R5: guard
      for (int f = 0; f < 3; f++) send_frame(2'b00, 1'b0);
      chk("R5", "headers ignored during guard", slip_rises, 1);
      idle(30);
      send_frame(2'b00, 1'b0);
      idle(14);
      chk("R5", "header judged after guard", slip_rises, 2);
      chk("R4", "second slide pulse width", last_slip_w, 2);
      chk("R9", "even position gives reset", rst_rises, 1);
      chk("R9", "reset length", last_rst_w, 10);

      // R4: run cleared by an invalid header
      idle(60);
      for (int f = 0; f < 20; f++) send_frame(2'b01, 1'b1);
      send_frame(2'b00, 1'b1);
      idle(4);
      chk("R4", "invalid header in confirm slides", slip_rises, 3);
      chk("R9", "third slide odd, no reset", rst_rises, 1);
      idle(60);
      for (int f = 0; f < 31; f++) send_frame(2'b10, 1'b1);
      idle(2);
      chk("R4", "run restarted after slide", locked, 0);
      send_frame(2'b01, 1'b1);
      idle(2);
      chk("R3", "lock after fresh 32 run", locked, 1);
      chk("R1", "one strobe per frame", strobe_cnt, frames_started);

      // R10: random offset acquisition with the stream model
      for (int t = 0; t < 3; t++) begin
         rst_n = 1'b0;
         idle(3);
         rst_n  = 1'b1;
         widx   = 0;
         m_prev = 1'b0;
         base   = $urandom % 256;
         ptr    = longint'(base) + 2560;
         for (int c = 0; c < 30000 && !locked; c++) model_cycle();
         chk("R10", "lock acquired", locked, 1);
         chk("R10", "word 0 on frame boundary", w0_ptr % 256, 0);
         sr = slip_rises;
         for (int c = 0; c < 600; c++) model_cycle();
         chk("R10", "lock held on clean data", locked, 1);
         chk("R10", "no slide while aligned", slip_rises, sr);
      end
      idle(2);
      chk("R8", "never slide while locked", lock_slip_viol, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule